// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command at a time over a bus of one, two, four or eight data lines at single data rate. Software programs a small set of registers through a write port: a transfer-mode field, a phase-configuration word that picks the line count of each phase, a dummy-cycle count, a byte count, an address and an opcode. A write that completes the programming starts the command. The sequencer then drives chip select low, enables the serial clock and steps through the opcode, address, dummy and data phases. Any phase whose mode is zero is skipped.

In the data phase of a write, the sequencer pulls one byte per byte-time from a byte input. In the data phase of a read, it releases the data lines and assembles bytes from the input lines. Sticky completion and error flags report the outcome and are cleared by writing ones to a flag-clear register. A self-clearing abort bit stops a running command at once.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset, cs_n is 1, sck_en, busy, done_flag, err_flag and abort_q are 0, and io_oe and io_out are 0.
- R2: Register selects are 0 control ([1:0] transfer mode, [2] abort), 1 phase config, 2 dummy count, 3 byte count, 4 address, 5 opcode and 6 flag clear. When the address mode is 0, an opcode write starts the command. When the address mode is non-zero, an opcode write only stores the opcode and the address write starts the command. The first phase appears in the cycle after the starting write.
- R3: Phase config holds opcode mode in [2:0], address mode in [5:3], address size in [7:6] and data mode in [10:8]. Mode 0 skips the phase, and modes 1, 2, 3 and 4 use 1, 2, 4 and 8 lines. Each byte takes 8/lines clock cycles, and a driven phase enables exactly the lowest lines of io_oe. Phases run in the order opcode, address, dummy, data.
- R4: Bits leave most significant first. In each cycle the group of `lines` bits is placed on io_out with its least significant bit on line 0.
- R5: The address size field holds the byte count minus one. The sequencer sends that many low-order bytes of the address register, the most significant of them first.
- R6: The dummy phase lasts exactly the programmed number of cycles (5-bit field). During it the clock is enabled and io_oe is 0. A count of 0 skips the phase.
- R7: The byte count register holds the data byte count minus one. With transfer mode 0 (write), wbyte_take is high in the cycle at whose end each byte is taken from wbyte, and that byte is driven during the following byte-time.
- R8: With transfer mode 1 (read), the data phase leaves io_oe at 0 and samples the low `lines` bits of io_in each cycle, most significant group first. rbyte_valid pulses with the assembled byte in the cycle after its last group.
- R9: busy is high exactly while cs_n is low. done_flag sets when the last phase ends and holds until a flag-clear write with bit 0 set.
- R10: A starting write with transfer mode 2 or 3, or with any phase mode above 4, starts no command and sets err_flag, which holds until a flag-clear write with bit 1 set.
- R11: A control write with bit 2 set ends any command at once. From the next cycle cs_n is 1, all lines are released and done_flag is not set. abort_q reads 1 for one cycle and then clears itself.
- R12: While busy, writes to the control mode, phase config, dummy count, byte count, address and opcode registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| fmode_q | output | 2 | Current transfer mode |
| abort_q | output | 1 | Abort bit, self-clearing |
| wbyte | input | 8 | Next byte to transmit |
| wbyte_take | output | 1 | wbyte is consumed at the end of this cycle |
| rbyte | output | 8 | Last received byte |
| rbyte_valid | output | 1 | rbyte is new this cycle |
| sck_en | output | 1 | Serial clock enable |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 8 | Data line output values |
| io_oe | output | 8 | Data line output enables |
| io_in | input | 8 | Data line input values |
| busy | output | 1 | Command in progress |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky error flag |

## Verification
The hardest situation to reach is a change to configuration or byte-count registers in the middle of a command. Its effect shows only on a later command that reuses the stored settings. The stimulus writes new values while a read is in flight, then triggers a second command without reprogramming and expects the waveform of the first. A second hard case is a write command with no opcode or address phase, where the first byte is taken in the same cycle as the triggering write. A dedicated data-only command covers it.

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq #(
  parameter int LEN_W  = 16,
  parameter int DCYC_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [1:0]  fmode_q,
  output logic        abort_q,
  input  logic [7:0]  wbyte,
  output logic        wbyte_take,
  output logic [7:0]  rbyte,
  output logic        rbyte_valid,
  output logic        sck_en,
  output logic        cs_n,
  output logic [7:0]  io_out,
  output logic [7:0]  io_oe,
  input  logic [7:0]  io_in,
  output logic        busy,
  output logic        done_flag,
  output logic        err_flag
);
  localparam int CW = (DCYC_W > 6) ? DCYC_W : 6;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_COMM = 3'd1, SEL_DUMMY = 3'd2,
                         SEL_DLEN = 3'd3, SEL_ADDR = 3'd4, SEL_INST = 3'd5,
                         SEL_CLR  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_INST, S_ADDR, S_DUMMY, S_DATA} phase_t;

  phase_t state, nxt;
  logic [1:0] fmode;
  logic abort_r, rvalid_r, done_r, err_r;
  logic [2:0] imode, amode, dmode;
  logic [1:0] asz;
  logic [DCYC_W-1:0] dcyc;
  logic [LEN_W-1:0] dlen, left;
  logic [31:0] addr_r, sh;
  logic [7:0] inst_r, acc, rbyte_r;
  logic [CW-1:0] cnt;

  function automatic phase_t pick(input logic [2:0] p, input logic [2:0] im, am, dm,
                                  input logic dz);
    phase_t r = S_IDLE;
    if (p <= 3'd4 && dm != 3'd0) r = S_DATA;
    if (p <= 3'd3 && !dz)        r = S_DUMMY;
    if (p <= 3'd2 && am != 3'd0) r = S_ADDR;
    if (p <= 3'd1 && im != 3'd0) r = S_INST;
    return r;
  endfunction

  wire busy_w   = state != S_IDLE;
  wire wr_ctrl  = reg_we && reg_sel == SEL_CTRL;
  wire wr_idle  = reg_we && !busy_w;
  wire do_abort = wr_ctrl && reg_wdata[2];
  wire trig     = wr_idle && ((reg_sel == SEL_INST && amode == 3'd0) ||
                              (reg_sel == SEL_ADDR && amode != 3'd0));
  wire bad      = fmode[1] || imode > 3'd4 || amode > 3'd4 || dmode > 3'd4;
  wire go       = trig && !bad;

  wire [2:0] cur_mode = (state == S_INST) ? imode : (state == S_ADDR) ? amode :
                        (state == S_DATA) ? dmode : 3'd0;
  wire [3:0] lines = (cur_mode == 3'd0) ? 4'd0 : 4'd1 << (cur_mode - 3'd1);
  wire [7:0] mask  = 8'((9'd1 << lines) - 9'd1);
  wire [7:0] grp   = sh[31:24] >> (4'd8 - lines);
  wire [7:0] acc_n = (acc << lines) | (io_in & mask);
  wire       drive = state == S_INST || state == S_ADDR || (state == S_DATA && fmode == 2'd0);

  wire last_cyc   = cnt == CW'(1);
  wire more_bytes = state == S_DATA && left != '0;
  wire adv        = go || (busy_w && last_cyc && !more_bytes);
  wire [2:0] from = go ? 3'd1 : 3'(state) + 3'd1;
  assign nxt = pick(from, imode, amode, dmode, dcyc == '0);

  wire [7:0]  inst_v = (reg_we && reg_sel == SEL_INST) ? reg_wdata[7:0] : inst_r;
  wire [31:0] addr_v = (reg_we && reg_sel == SEL_ADDR) ? reg_wdata : addr_r;
  wire [2:0]  nmode  = (nxt == S_INST) ? imode : (nxt == S_ADDR) ? amode : dmode;
  wire [CW-1:0] byte_cyc = CW'(4'd8 >> (nmode - 3'd1));
  wire [CW-1:0] dat_cyc  = CW'(4'd8 >> (dmode - 3'd1));
  wire [5:0]    abits    = {1'b0, asz, 3'b000} + 6'd8;

  assign wbyte_take = !do_abort && fmode == 2'd0 &&
                      ((adv && nxt == S_DATA) || (more_bytes && last_cyc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; fmode <= 2'd0; abort_r <= 1'b0; rvalid_r <= 1'b0;
      done_r <= 1'b0; err_r <= 1'b0; imode <= 3'd0; amode <= 3'd0; dmode <= 3'd0;
      asz <= 2'd0; dcyc <= '0; dlen <= '0; left <= '0; addr_r <= '0; sh <= '0;
      inst_r <= '0; acc <= '0; rbyte_r <= '0; cnt <= '0;
    end else begin
      rvalid_r <= 1'b0;
      abort_r  <= do_abort;
      if (wr_idle && reg_sel == SEL_CTRL)  fmode <= reg_wdata[1:0];
      if (wr_idle && reg_sel == SEL_COMM) begin
        imode <= reg_wdata[2:0]; amode <= reg_wdata[5:3];
        asz   <= reg_wdata[7:6]; dmode <= reg_wdata[10:8];
      end
      if (wr_idle && reg_sel == SEL_DUMMY) dcyc   <= reg_wdata[DCYC_W-1:0];
      if (wr_idle && reg_sel == SEL_DLEN)  dlen   <= reg_wdata[LEN_W-1:0];
      if (wr_idle && reg_sel == SEL_ADDR)  addr_r <= reg_wdata;
      if (wr_idle && reg_sel == SEL_INST)  inst_r <= reg_wdata[7:0];
      if (reg_we && reg_sel == SEL_CLR) begin
        if (reg_wdata[0]) done_r <= 1'b0;
        if (reg_wdata[1]) err_r  <= 1'b0;
      end
      if (trig && bad) err_r <= 1'b1;

      if (do_abort) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (busy_w || go) begin
        if (state == S_DATA && fmode == 2'd1) begin
          acc <= acc_n;
          if (last_cyc) begin rbyte_r <= acc_n; rvalid_r <= 1'b1; end
        end
        if (adv) begin
          state <= nxt;
          case (nxt)
            S_INST:  begin sh <= {inst_v, 24'd0}; cnt <= byte_cyc; end
            S_ADDR:  begin sh <= addr_v << {2'd3 - asz, 3'b000};
                           cnt <= CW'(abits >> (amode - 3'd1)); end
            S_DUMMY: begin sh <= '0; cnt <= CW'(dcyc); end
            S_DATA:  begin sh <= {wbyte, 24'd0}; cnt <= byte_cyc; left <= dlen; acc <= '0; end
            default: begin cnt <= '0; done_r <= 1'b1; end
          endcase
        end else if (last_cyc) begin
          left <= left - 1'b1;
          cnt  <= dat_cyc;
          sh   <= {wbyte, 24'd0};
        end else begin
          cnt <= cnt - 1'b1;
          sh  <= sh << lines;
        end
      end
    end
  end

  assign fmode_q     = fmode;
  assign abort_q     = abort_r;
  assign rbyte       = rbyte_r;
  assign rbyte_valid = rvalid_r;
  assign sck_en      = busy_w;
  assign cs_n        = !busy_w;
  assign busy        = busy_w;
  assign io_oe       = drive ? mask : 8'd0;
  assign io_out      = drive ? (grp & mask) : 8'd0;
  assign done_flag   = done_r;
  assign err_flag    = err_r;

  p_abort_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_abort |=> (cs_n && io_oe == 8'd0 && abort_q));
  p_abort_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);
  p_lane_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (io_oe inside {8'h00, 8'h01, 8'h03, 8'h0F, 8'hFF}));
  p_take_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_take |-> fmode_q == 2'd0);
  p_rvalid_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rbyte_valid |-> (fmode_q == 2'd1 && io_oe == 8'd0));
  p_bad_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && bad) |=> (cs_n && err_flag));
  p_busy_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && reg_we && reg_sel == SEL_COMM) |=>
      (imode == $past(imode) && amode == $past(amode) && dmode == $past(dmode)));
  p_busy_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
endmodule

// File: tb/sim_sflash_cmd_seq.sv
module sim_sflash_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [7:0] wbyte = 8'd0, io_in = 8'd0;
  logic [1:0] fmode_q;
  logic abort_q, wbyte_take, rbyte_valid, sck_en, cs_n, busy, done_flag, err_flag;
  logic [7:0] rbyte, io_out, io_oe;

  sflash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .fmode_q(fmode_q), .abort_q(abort_q), .wbyte(wbyte), .wbyte_take(wbyte_take),
    .rbyte(rbyte), .rbyte_valid(rbyte_valid), .sck_en(sck_en), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .busy(busy),
    .done_flag(done_flag), .err_flag(err_flag));

  typedef struct packed {
    logic sck; logic [7:0] oe; logic [7:0] dq; logic take; logic rv;
    logic [7:0] rb; logic [7:0] din; logic [7:0] wb; logic [3:0] req;
  } ent_t;

  ent_t q[$];
  int nchk = 0, nfail = 0, dseed = 0;
  logic pend_rv = 1'b0;
  logic [7:0] pend_rb = 8'd0;
  logic [3:0] ctx = 4'd1;

  function automatic int lw(input int code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  function automatic logic [7:0] msk(input int l);
    return 8'((1 << l) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic [7:0] oe, input logic [7:0] dq,
                      input logic [3:0] rq, input logic [7:0] din);
    ent_t e;
    e = '0; e.sck = s; e.oe = oe; e.dq = dq; e.req = rq; e.din = din;
    e.rv = pend_rv; e.rb = pend_rb; pend_rv = 1'b0;
    q.push_back(e);
  endtask

  task automatic mark_take(input logic [7:0] b);
    ent_t e;
    e = q.pop_back(); e.take = 1'b1; e.wb = b; q.push_back(e);
  endtask

  // one clock: drive inputs just after the rising edge, compare at the falling edge
  task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] d);
    ent_t e;
    @(posedge clk); #1;
    reg_we = we; reg_sel = sel; reg_wdata = d;
    if (q.size() > 0) begin io_in = q[0].din; wbyte = q[0].wb; end
    @(negedge clk);
    e = '0; e.req = ctx;
    if (q.size() > 0) e = q.pop_front();
    nchk++;
    if (sck_en !== e.sck || cs_n !== !e.sck || busy !== e.sck || io_oe !== e.oe ||
        io_out !== e.dq || wbyte_take !== e.take || rbyte_valid !== e.rv ||
        (e.rv && rbyte !== e.rb)) begin
      nfail++;
      $display("FAIL R%0d actual sck=%b oe=%h dq=%h take=%b rv=%b rb=%h expected sck=%b oe=%h dq=%h take=%b rv=%b rb=%h",
               e.req, sck_en, io_oe, io_out, wbyte_take, rbyte_valid, rbyte,
               e.sck, e.oe, e.dq, e.take, e.rv, e.rb);
    end
  endtask

  task automatic run(input int fm, input int im, input int am, input int asz, input int dm,
                     input int dc, input int len, input logic [7:0] inst, input logic [31:0] addr,
                     input bit cfg, input int stop_at, input bit meddle);
    int l, bits, k;
    logic [7:0] mk, b, acc, din;
    logic [63:0] v;
    if (cfg) begin
      cyc(1'b1, 3'd0, 32'(fm));
      cyc(1'b1, 3'd1, 32'(im | (am << 3) | (asz << 6) | (dm << 8)));
      cyc(1'b1, 3'd2, 32'(dc));
      cyc(1'b1, 3'd3, 32'(len));
    end
    if (am != 0) cyc(1'b1, 3'd5, {24'd0, inst});
    push(1'b0, 8'd0, 8'd0, ctx, 8'd0);
    if (im != 0) begin // R3 R4 opcode phase
      l = lw(im); mk = msk(l);
      for (int j = 0; j < 8 / l; j++) push(1'b1, mk, 8'((inst >> (8 - l * (j + 1))) & mk), 4'd3, 8'd0);
    end
    if (am != 0) begin // R5 address phase
      l = lw(am); mk = msk(l); bits = 8 * (asz + 1);
      v = 64'(addr) & ((64'd1 << bits) - 64'd1);
      for (int j = 0; j < bits / l; j++) push(1'b1, mk, 8'((v >> (bits - l * (j + 1))) & 64'(mk)), 4'd5, 8'd0);
    end
    for (int j = 0; j < dc; j++) push(1'b1, 8'd0, 8'd0, 4'd6, 8'd0); // R6 dummy
    if (dm != 0) begin
      l = lw(dm); mk = msk(l);
      for (int bi = 0; bi <= len; bi++) begin
        if (fm == 0) begin // R7 write data
          b = 8'(inst + 8'(17 * bi) + 8'd5);
          mark_take(b);
          for (int j = 0; j < 8 / l; j++) push(1'b1, mk, 8'((b >> (8 - l * (j + 1))) & mk), 4'd7, 8'd0);
        end else begin // R8 read data
          acc = 8'd0;
          for (int j = 0; j < 8 / l; j++) begin
            din = 8'(dseed * 53 + 11); dseed++;
            acc = 8'((acc << l) | (din & mk));
            push(1'b1, 8'd0, 8'd0, 4'd8, din);
          end
          pend_rv = 1'b1; pend_rb = acc;
        end
      end
    end
    push(1'b0, 8'd0, 8'd0, 4'd9, 8'd0);
    if (am != 0) cyc(1'b1, 3'd4, addr); else cyc(1'b1, 3'd5, {24'd0, inst});
    k = 0;
    while (q.size() > 0) begin
      if (k == stop_at) begin
        cyc(1'b1, 3'd0, 32'(fm | 4));
        q.delete(); pend_rv = 1'b0;
        break;
      end else if (meddle && k == 2) cyc(1'b1, 3'd1, 32'h0000_0249);
      else if (meddle && k == 3) cyc(1'b1, 3'd3, 32'd0);
      else if (meddle && k == 4) cyc(1'b1, 3'd2, 32'd1);
      else cyc(1'b0, 3'd0, 32'd0);
      if (k == 0) chk(busy === 1'b1, "R2 start after trigger write busy", 32'(busy), 32'd1);
      k++;
    end
  endtask

  task automatic finish_cmd();
    chk(done_flag === 1'b1, "R9 done after last phase", 32'(done_flag), 32'd1);
    cyc(1'b1, 3'd6, 32'd1);
    cyc(1'b0, 3'd0, 32'd0);
    chk(done_flag === 1'b0, "R9 done cleared by flag clear", 32'(done_flag), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ctx = 4'd1;
    cyc(1'b0, 3'd0, 32'd0);
    // R1 reset state
    chk(cs_n === 1'b1 && sck_en === 1'b0 && io_oe === 8'd0 && io_out === 8'd0,
        "R1 bus idle after reset", {cs_n, sck_en, io_oe, io_out}, 32'h20000);
    chk(busy === 1'b0 && done_flag === 1'b0 && err_flag === 1'b0 && abort_q === 1'b0,
        "R1 flags clear after reset", {busy, done_flag, err_flag, abort_q}, 32'd0);

    ctx = 4'd2;
    run(0, 1, 0, 0, 0, 0, 0, 8'h9E, 32'd0, 1, -1, 0);       // R2 opcode-only, single line
    finish_cmd();
    run(1, 1, 1, 2, 1, 8, 2, 8'h0B, 32'hFFA1_B2C3, 1, -1, 0); // R5 R6 R8 single-line read
    finish_cmd();
    ctx = 4'd3;
    run(0, 3, 3, 3, 3, 0, 3, 8'h38, 32'h1234_5678, 1, -1, 0); // quad write
    finish_cmd();
    run(1, 4, 4, 3, 4, 5, 4, 8'hEC, 32'hCAFE_0F1D, 1, -1, 0); // octal read
    finish_cmd();
    run(0, 2, 2, 0, 2, 3, 1, 8'hA2, 32'h0000_00B7, 1, -1, 0); // dual write, one-byte address
    finish_cmd();
    ctx = 4'd7;
    run(0, 0, 0, 0, 4, 0, 1, 8'h61, 32'd0, 1, -1, 0);         // data-only write, take at trigger
    finish_cmd();

    // R10 bad transfer mode and bad phase mode
    ctx = 4'd10;
    cyc(1'b1, 3'd0, 32'd3);
    cyc(1'b1, 3'd1, 32'd1);
    cyc(1'b1, 3'd5, 32'h05);
    cyc(1'b0, 3'd0, 32'd0);
    chk(err_flag === 1'b1 && cs_n === 1'b1, "R10 mode 3 refused", {err_flag, cs_n}, 32'd3);
    cyc(1'b1, 3'd6, 32'd2);
    cyc(1'b0, 3'd0, 32'd0);
    chk(err_flag === 1'b0, "R10 error cleared", 32'(err_flag), 32'd0);
    cyc(1'b1, 3'd0, 32'd0);
    cyc(1'b1, 3'd1, 32'd5);
    cyc(1'b1, 3'd5, 32'h06);
    cyc(1'b0, 3'd0, 32'd0);
    chk(err_flag === 1'b1 && cs_n === 1'b1 && done_flag === 1'b0, "R10 phase code 5 refused",
        {err_flag, cs_n, done_flag}, 32'd6);
    cyc(1'b1, 3'd6, 32'd2);

    // R12 writes while busy are ignored; a re-trigger reuses the old settings
    ctx = 4'd12;
    run(1, 1, 2, 1, 2, 4, 1, 8'h3B, 32'h0000_5AC3, 1, -1, 1);
    finish_cmd();
    run(1, 1, 2, 1, 2, 4, 1, 8'h3B, 32'h0000_5AC3, 0, -1, 0);
    finish_cmd();

    // R11 abort mid data phase
    ctx = 4'd11;
    run(0, 1, 0, 0, 1, 0, 3, 8'hA5, 32'd0, 1, 10, 0);
    cyc(1'b0, 3'd0, 32'd0);
    chk(abort_q === 1'b1 && cs_n === 1'b1 && io_oe === 8'd0, "R11 stopped, abort bit visible",
        {abort_q, cs_n, io_oe}, 32'h300);
    cyc(1'b0, 3'd0, 32'd0);
    chk(abort_q === 1'b0, "R11 abort bit self-clears", 32'(abort_q), 32'd0);
    chk(done_flag === 1'b0, "R11 no completion after abort", 32'(done_flag), 32'd0);
    run(0, 1, 0, 0, 0, 0, 0, 8'h66, 32'd0, 1, -1, 0);
    finish_cmd();

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule